// File: doc/BRIEF.md
# Shift-Chain Upset and Functional-Interrupt Monitor

This block watches the serial output of a long register chain whose input is a square wave at half the clock rate. Because the inverters that may sit between chain stages cancel in pairs, a healthy chain delivers a stream that toggles on every clock. The chain's latency is not known, so either starting phase is accepted. The monitor shifts the chain output into a four-bit group. On a strobe that fires once every eighth enabled clock, it decides whether that group is clean, meaning every pair of neighbouring bits differs.

Each faulty group adds one to a saturating upset count and raises a one-cycle error pulse. Faulty groups that follow one another back to back are tracked by a run counter. When 500 of them occur in a row, a separate saturating functional-interrupt count goes up by one and the run counter starts again from zero. A clean group clears the run. While the enable input is low, the monitor stands still.

Top module: `chain_seu_monitor`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `upset_cnt_o` and `sefi_cnt_o` are zero and `err_pulse_o` is low.
- R2: Counting enabled clock edges from 1 after reset or after the enable returns high, a check takes place on edges 8, 16, 24 and so on. It judges the bits sampled on the four enabled edges just before the check edge (for example edges 4 to 7). A bit sampled on any other edge is never judged.
- R3: A group is clean when each adjacent pair of its four bits differs. Both 0101 and 1010 are clean, so a one-bit phase slip that falls outside a judged window causes no upset.
- R4: `err_pulse_o` is high for exactly the one cycle that follows a check edge that found a faulty group, and is low at all other times.
- R5: `upset_cnt_o` rises by exactly one for each faulty check and does not change otherwise.
- R6: A clean check clears the run of consecutive faulty checks, so two runs of fewer than 500 that are separated by a clean check produce no functional-interrupt event.
- R7: The 500th faulty check in an unbroken run adds one to `sefi_cnt_o` and restarts the run at zero. Each further 500 adds one more.
- R8: Both counts stop at their all-ones value and never wrap.
- R9: While `enable_i` is low, no check takes place, `err_pulse_o` stays low, both counts hold, and the strobe divider restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Monitor clock, shared with the chain |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chain_bit_i | input | 1 | Serial output of the chain under test |
| enable_i | input | 1 | Monitoring enable |
| upset_cnt_o | output | UPSET_W | Saturating count of faulty checks |
| sefi_cnt_o | output | SEFI_W | Saturating count of functional-interrupt events |
| err_pulse_o | output | 1 | One-cycle pulse after each faulty check |

## Verification
The hardest situation to reach is counter saturation, and the functional-interrupt count in particular, because it needs thousands of back-to-back faulty checks. The bench narrows both count widths and holds the chain input stuck for long stretches so that both counts reach all-ones in a short run. Single-bit flips are placed at chosen slots of the eight-edge strobe cycle, using the reference model's divider position, to show the sampling window. A clean gap is inserted between two runs that each stay just under 500 to show that the run is cleared.

// File: rtl/chain_mon_pkg.sv
package chain_mon_pkg;

  // Outcome of one clock of the sampler: whether a check happens and its verdict.
  typedef struct packed {
    logic strobe;
    logic faulty;
  } check_t;

endpackage

// File: rtl/chain_mon_sampler.sv
module chain_mon_sampler
  import chain_mon_pkg::*;
#(
  parameter int GROUP_W    = 4,
  parameter int STROBE_DIV = 8
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   en_i,
  input  logic   bit_i,
  output check_t chk_o
);

  localparam int CNT_W = (STROBE_DIV > 1) ? $clog2(STROBE_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STROBE_DIV - 1);

  logic [CNT_W-1:0]   div_q, div_d;
  logic [GROUP_W-1:0] grp_q, grp_d;
  logic [GROUP_W-2:0] pair_same;

  // One flag per neighbouring pair, set when the two bits match.
  for (genvar i = 0; i < GROUP_W - 1; i++) begin : g_pair
    assign pair_same[i] = ~(grp_q[i] ^ grp_q[i+1]);
  end

  always_comb begin
    chk_o.strobe = en_i && (div_q == LAST);
    chk_o.faulty = chk_o.strobe && (|pair_same);
  end

  always_comb begin
    div_d = div_q;
    grp_d = grp_q;
    if (!en_i) begin
      div_d = '0;
    end else begin
      div_d = (div_q == LAST) ? '0 : div_q + 1'b1;
      grp_d = {grp_q[GROUP_W-2:0], bit_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      grp_q <= '0;
    end else begin
      div_q <= div_d;
      grp_q <= grp_d;
    end
  end

  AST_DIV_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (div_q == '0)) else $error("divider not restarted"); // R9

  AST_GROUP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(grp_q)) else $error("group moved while idle"); // R9

endmodule

// File: rtl/chain_mon_run_tracker.sv
module chain_mon_run_tracker #(
  parameter int RUN_LEN = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic faulty_i,
  output logic event_o
);

  localparam int RUN_W = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);

  logic [RUN_W-1:0] run_q, run_d;

  always_comb begin
    event_o = strobe_i && faulty_i && (run_q == RUN_LAST);
    run_d   = run_q;
    if (strobe_i) begin
      if (!faulty_i || event_o) run_d = '0;
      else                      run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else         run_q <= run_d;
  end

  AST_RUN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= RUN_LAST) else $error("run counter out of range"); // R7

  AST_RUN_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && !faulty_i |=> run_q == '0) else $error("clean check kept run"); // R6

  AST_RUN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(run_q)) else $error("run moved without check"); // R9

endmodule

// File: rtl/chain_mon_sat_ctr.sv
module chain_mon_sat_ctr #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         full;

  always_comb begin
    full  = &cnt_q;
    cnt_d = cnt_q;
    if (inc_i && !full) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cnt_q) |=> (&cnt_q)) else $error("counter wrapped"); // R8

  AST_HOLD_NO_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_q)) else $error("counter moved without increment"); // R5

endmodule

// File: rtl/chain_seu_monitor.sv
module chain_seu_monitor
  import chain_mon_pkg::*;
#(
  parameter int GROUP_W    = 4,
  parameter int STROBE_DIV = 8,
  parameter int SEFI_RUN   = 500,
  parameter int UPSET_W    = 16,
  parameter int SEFI_W     = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               chain_bit_i,
  input  logic               enable_i,
  output logic [UPSET_W-1:0] upset_cnt_o,
  output logic [SEFI_W-1:0]  sefi_cnt_o,
  output logic               err_pulse_o
);

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  check_t chk;
  logic   sefi_evt;
  logic   err_q, err_d;

  chain_mon_sampler #(
    .GROUP_W   (GROUP_W),
    .STROBE_DIV(STROBE_DIV)
  ) sampler_i (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .en_i  (enable_i),
    .bit_i (chain_bit_i),
    .chk_o (chk)
  );

  chain_mon_run_tracker #(
    .RUN_LEN(SEFI_RUN)
  ) run_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .strobe_i(chk.strobe),
    .faulty_i(chk.faulty),
    .event_o (sefi_evt)
  );

  chain_mon_sat_ctr #(.W(UPSET_W)) upset_ctr_i (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .inc_i (chk.faulty),
    .cnt_o (upset_cnt_o)
  );

  chain_mon_sat_ctr #(.W(SEFI_W)) sefi_ctr_i (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .inc_i (sefi_evt),
    .cnt_o (sefi_cnt_o)
  );

  always_comb err_d = chk.faulty;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign err_pulse_o = err_q;

  AST_PULSE_AFTER_CHECK: assert property (@(posedge clk_i) disable iff (!rst_n)
    err_q |-> $past(chk.strobe)) else $error("pulse without check"); // R4

  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_n)
    err_q |=> !err_q) else $error("pulse longer than one cycle"); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n)
    !enable_i |=> !err_q) else $error("pulse while disabled"); // R9

  AST_SEFI_ONLY_ON_ERR: assert property (@(posedge clk_i) disable iff (!rst_n)
    !err_d |=> $stable(sefi_cnt_o)) else $error("event count moved on clean cycle"); // R7

endmodule

// File: tb/chain_seu_monitor_tb_top.sv
`timescale 1ns/1ps
module chain_seu_monitor_tb_top;

  localparam int CLK_PERIOD = 5;
  localparam int GW  = 4;
  localparam int DIV = 8;
  localparam int RUN = 500;
  localparam int UW  = 10;
  localparam int SW  = 2;
  localparam int UMAX = (1 << UW) - 1;
  localparam int SMAX = (1 << SW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic din = 1'b0;
  logic [UW-1:0] upset_cnt;
  logic [SW-1:0] sefi_cnt;
  logic err_pulse;

  always #(CLK_PERIOD / 2.0) clk = ~clk;

  chain_seu_monitor #(
    .GROUP_W(GW), .STROBE_DIV(DIV), .SEFI_RUN(RUN), .UPSET_W(UW), .SEFI_W(SW)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .chain_bit_i(din), .enable_i(en),
    .upset_cnt_o(upset_cnt), .sefi_cnt_o(sefi_cnt), .err_pulse_o(err_pulse)
  );

  // Reference model state
  int m_cnt, m_ups, m_sefi, m_run;
  bit m_pulse;
  bit m_hist[$];
  int n_cmp, n_bad;
  bit ph;

  task automatic report(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit bad;
    if (!rst_n) begin
      m_cnt = 0; m_ups = 0; m_sefi = 0; m_run = 0; m_pulse = 0;
      m_hist.delete();
      for (int i = 0; i < GW; i++) m_hist.push_back(1'b0);
    end else if (en) begin
      m_pulse = 0;
      if (m_cnt == DIV - 1) begin
        bad = 0;
        for (int i = 0; i < GW - 1; i++) if (m_hist[i] == m_hist[i+1]) bad = 1;
        m_pulse = bad;
        if (bad) begin
          if (m_ups < UMAX) m_ups++;
          if (m_run == RUN - 1) begin
            m_run = 0;
            if (m_sefi < SMAX) m_sefi++;
          end else m_run++;
        end else m_run = 0;
        m_cnt = 0;
      end else m_cnt++;
      m_hist.push_back(din);
      void'(m_hist.pop_front());
    end else begin
      m_cnt = 0; m_pulse = 0;
    end
  endtask

  task automatic cycle(input bit e, input bit d);
    @(negedge clk);
    report("R4 err_pulse", int'(err_pulse), int'(m_pulse));
    report("R5 upset_cnt", int'(upset_cnt), m_ups);
    report("R7 sefi_cnt", int'(sefi_cnt), m_sefi);
    en = e; din = d;
    @(posedge clk);
    model_edge();
  endtask

  task automatic run_alt(int n);
    for (int i = 0; i < n; i++) begin ph = ~ph; cycle(1'b1, ph); end
  endtask

  task automatic run_stuck(int n, bit v);
    for (int i = 0; i < n; i++) cycle(1'b1, v);
  endtask

  // Advance alternately until the divider is at slot pos, then inject.
  task automatic run_to_slot(int pos);
    while (m_cnt != pos) run_alt(1);
  endtask

  bit done = 0;
  int base_u, base_s;

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    ph = 0;
    model_edge();
    repeat (3) @(negedge clk);
    report("R1 upset in reset", int'(upset_cnt), 0);
    report("R1 sefi in reset", int'(sefi_cnt), 0);
    report("R1 pulse in reset", int'(err_pulse), 0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 4; i++) cycle(1'b0, 1'b0);
    report("R1 upset after reset", int'(upset_cnt), 0);

    // Clean alternating stream, one phase
    run_alt(200);
    report("R3 clean stream", int'(upset_cnt), 0);

    // Phase slip at an unjudged slot: the stream resumes in the opposite phase
    run_to_slot(1);
    cycle(1'b1, ph);
    run_alt(200);
    report("R3 phase slip unjudged", int'(upset_cnt), 0);

    // Isolated flip outside the window
    run_to_slot(1);
    ph = ~ph; cycle(1'b1, ~ph);
    run_alt(40);
    report("R2 flip outside window", int'(upset_cnt), 0);

    // Isolated flip inside the window
    run_to_slot(4);
    ph = ~ph; cycle(1'b1, ~ph);
    run_alt(40);
    report("R2 flip inside window", int'(upset_cnt), 1);
    report("R5 one upset", m_ups, 1);

    // Two sub-threshold runs separated by clean checks
    run_stuck(490 * DIV, 1'b0);
    run_alt(40);
    run_stuck(490 * DIV, 1'b0);
    report("R6 runs cleared", int'(sefi_cnt), 0);

    // Enable low: everything holds
    base_u = int'(upset_cnt); base_s = int'(sefi_cnt);
    for (int i = 0; i < 60; i++) begin
      cycle(1'b0, 1'b0);
      report("R9 pulse idle", int'(err_pulse), 0);
    end
    report("R9 upset hold", int'(upset_cnt), base_u);
    report("R9 sefi hold", int'(sefi_cnt), base_s);

    // Continue the run past two thresholds
    run_stuck(600 * DIV, 1'b0);
    report("R7 two events", int'(sefi_cnt), 2);
    report("R8 upset saturated", int'(upset_cnt), UMAX);

    run_stuck(1100 * DIV, 1'b1);
    report("R8 sefi saturated", int'(sefi_cnt), SMAX);
    report("R8 upset stays", int'(upset_cnt), UMAX);

    run_alt(20);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule